// File: doc/BRIEF.md
# Sector Page Load Buffer

This block gathers the bytes of one 256-byte sector into an internal page buffer and then commits that page to an external memory array in a single timed cycle. A write strobe carries an 18-bit byte address and a data byte. The upper ten address bits name the sector and the lower eight bits name the byte inside it. A write that arrives while the block is idle with the program-enable flag high opens a load and fixes the sector. Later writes to the same sector fill the buffer in any order. When no accepted write arrives for a set number of clock ticks, the load window closes on its own.

The commit cycle has a fixed length. It first sweeps every position of the sector to the erased value FF. It then sweeps the buffer contents into the array. Every position that was never loaded therefore reads FF afterwards. Two lockout flags protect the lowest and highest 8 KB of the array. A load aimed at a protected sector still runs the full cycle, but it writes nothing. The busy flag covers the whole cycle. The address and data of the last byte the block accepted are available at the ports.

Top module: `spl_sector_loader`

## Requirements
- R1: After reset, busy and arr_we are 0, and last_addr and last_data are 0.
- R2: While idle, a write with prog_en high opens a load for sector wr_addr[17:8]. A write with prog_en low is ignored: it opens no load and changes neither last_addr nor last_data.
- R3: During a load, writes to the latched sector may target byte positions wr_addr[7:0] in any order. A repeated position keeps the last data written. last_addr and last_data show the most recent accepted write.
- R4: During a load, a write whose sector differs from the latched one is ignored. It stores no data, leaves last_addr unchanged and does not restart the inactivity timer.
- R5: busy rises exactly TIMEOUT_TICKS clock cycles after the edge that accepted the last byte.
- R6: busy stays high for exactly CYCLE_TICKS clock cycles.
- R7: The cycle writes only addresses inside the latched sector. It first writes FF to byte positions 0 to 255 in ascending order, then writes the buffer to positions 0 to 255. Positions that were not loaded end as FF.
- R8: lock_lo protects sectors 0 to 31 and lock_hi protects sectors 992 to 1023. Both flags are sampled when the cycle starts. A protected sector receives no array write, yet busy still lasts CYCLE_TICKS cycles.
- R9: Writes that arrive while busy is high are ignored. They change neither the array nor last_addr or last_data, and they open no new load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | One-cycle byte write strobe |
| wr_addr | input | 18 | Byte address: sector in [17:8], byte in [7:0] |
| wr_data | input | 8 | Byte to load |
| prog_en | input | 1 | Program enable, checked on the write that opens a load |
| lock_lo | input | 1 | Protects the lowest 8 KB |
| lock_hi | input | 1 | Protects the highest 8 KB |
| busy | output | 1 | Erase-and-program cycle in progress |
| last_addr | output | 18 | Address of the last accepted write |
| last_data | output | 8 | Data of the last accepted write |
| arr_we | output | 1 | Array write enable |
| arr_addr | output | 18 | Array write address |
| arr_data | output | 8 | Array write data |

## Verification
A wrong byte mask or a buffer entry written at the wrong position leaves a wrong value in the array model once the sweep ends. That error is visible within CYCLE_TICKS cycles of busy rising. A timer that restarts on the wrong event moves the rising edge of busy by a measurable number of cycles. A phase counter that is off by one changes the busy length, or it breaks the rule that the first 256 array writes carry FF in ascending order. A lock decision that is latched wrongly shows up as array writes that should not occur, or as writes that are missing.

// File: rtl/spl_pkg.sv
package spl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_ERASE,
    ST_PROG,
    ST_SETTLE
  } spl_state_e;

  localparam logic [7:0] SPL_ERASED = 8'hFF;
endpackage

// File: rtl/spl_page_buf.sv
module spl_page_buf #(
  parameter int BYTE_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              we,
  input  logic [BYTE_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [BYTE_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << BYTE_W;

  logic [DATA_W-1:0] data_q [DEPTH];
  logic [DEPTH-1:0]  valid_q;

  // data storage carries no reset; validity mask decides what is read
  always_ff @(posedge clk) begin
    if (we) data_q[waddr] <= wdata;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_valid
    logic hit;
    assign hit = we && (waddr == BYTE_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   valid_q[g] <= 1'b0;
      else if (clr) valid_q[g] <= hit;
      else if (hit) valid_q[g] <= 1'b1;
    end
  end

  assign rdata = valid_q[raddr] ? data_q[raddr] : {DATA_W{1'b1}};
endmodule

// File: rtl/spl_lock_dec.sv
module spl_lock_dec #(
  parameter int SECT_W      = 10,
  parameter int BOOT_SECTS  = 32
) (
  input  logic [SECT_W-1:0] sector,
  input  logic              lock_lo,
  input  logic              lock_hi,
  output logic              locked
);
  localparam int NSECT = 1 << SECT_W;
  localparam logic [SECT_W-1:0] LO_END   = SECT_W'(BOOT_SECTS);
  localparam logic [SECT_W-1:0] HI_START = SECT_W'(NSECT - BOOT_SECTS);

  logic in_lo, in_hi;
  always_comb begin
    in_lo  = sector < LO_END;
    in_hi  = sector >= HI_START;
    locked = (lock_lo && in_lo) || (lock_hi && in_hi);
  end
endmodule

// File: rtl/spl_load_ctrl.sv
module spl_load_ctrl
  import spl_pkg::*;
#(
  parameter int ADDR_W        = 18,
  parameter int BYTE_W        = 8,
  parameter int DATA_W        = 8,
  parameter int TIMEOUT_TICKS = 30000,
  parameter int CYCLE_TICKS   = 4000000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_stb,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     prog_en,
  input  logic                     sect_locked,
  output logic [ADDR_W-BYTE_W-1:0] sector,
  output logic [BYTE_W-1:0]        idx,
  output logic                     buf_clr,
  output logic                     buf_we,
  output logic                     erase_ph,
  output logic                     prog_ph,
  output logic                     busy,
  output logic                     locked,
  output logic [ADDR_W-1:0]        last_addr,
  output logic [DATA_W-1:0]        last_data
);
  localparam int SECT_W = ADDR_W - BYTE_W;
  localparam int TMR_W  = $clog2(TIMEOUT_TICKS + 1);
  localparam int CYC_W  = $clog2(CYCLE_TICKS + 1);
  localparam logic [BYTE_W-1:0] IDX_LAST = {BYTE_W{1'b1}};
  localparam logic [TMR_W-1:0]  TMR_END  = TMR_W'(TIMEOUT_TICKS - 1);
  localparam logic [CYC_W-1:0]  CYC_END  = CYC_W'(CYCLE_TICKS - 1);

  spl_state_e        state_q, state_d;
  logic [TMR_W-1:0]  tmr_q, tmr_d;
  logic [CYC_W-1:0]  cyc_q, cyc_d;
  logic [BYTE_W-1:0] idx_q, idx_d;
  logic [SECT_W-1:0] sector_q, sector_d;
  logic              locked_q, locked_d;
  logic [ADDR_W-1:0] last_addr_q, last_addr_d;
  logic [DATA_W-1:0] last_data_q, last_data_d;

  logic [SECT_W-1:0] wr_sect;
  logic              open_load, take_byte;

  assign wr_sect   = wr_addr[ADDR_W-1:BYTE_W];
  assign open_load = (state_q == ST_IDLE) && wr_stb && prog_en;
  assign take_byte = (state_q == ST_LOAD) && wr_stb && (wr_sect == sector_q);

  always_comb begin
    state_d     = state_q;
    tmr_d       = tmr_q;
    cyc_d       = cyc_q;
    idx_d       = idx_q;
    sector_d    = sector_q;
    locked_d    = locked_q;
    last_addr_d = last_addr_q;
    last_data_d = last_data_q;

    if (open_load || take_byte) begin
      last_addr_d = wr_addr;
      last_data_d = wr_data;
    end

    case (state_q)
      ST_IDLE: begin
        if (open_load) begin
          state_d  = ST_LOAD;
          sector_d = wr_sect;
          tmr_d    = '0;
        end
      end
      ST_LOAD: begin
        if (take_byte) begin
          tmr_d = '0;
        end else if (tmr_q == TMR_END) begin
          state_d  = ST_ERASE;
          cyc_d    = '0;
          idx_d    = '0;
          locked_d = sect_locked;
        end else begin
          tmr_d = tmr_q + 1'b1;
        end
      end
      ST_ERASE: begin
        cyc_d = cyc_q + 1'b1;
        idx_d = idx_q + 1'b1;
        if (idx_q == IDX_LAST) state_d = ST_PROG;
      end
      ST_PROG: begin
        cyc_d = cyc_q + 1'b1;
        idx_d = idx_q + 1'b1;
        if (idx_q == IDX_LAST) state_d = ST_SETTLE;
      end
      ST_SETTLE: begin
        if (cyc_q == CYC_END) state_d = ST_IDLE;
        else                  cyc_d   = cyc_q + 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      tmr_q       <= '0;
      cyc_q       <= '0;
      idx_q       <= '0;
      sector_q    <= '0;
      locked_q    <= 1'b0;
      last_addr_q <= '0;
      last_data_q <= '0;
    end else begin
      state_q     <= state_d;
      tmr_q       <= tmr_d;
      cyc_q       <= cyc_d;
      idx_q       <= idx_d;
      sector_q    <= sector_d;
      locked_q    <= locked_d;
      last_addr_q <= last_addr_d;
      last_data_q <= last_data_d;
    end
  end

  assign sector    = sector_q;
  assign idx       = idx_q;
  assign buf_clr   = open_load;
  assign buf_we    = open_load || take_byte;
  assign erase_ph  = (state_q == ST_ERASE);
  assign prog_ph   = (state_q == ST_PROG);
  assign busy      = (state_q == ST_ERASE) || (state_q == ST_PROG) || (state_q == ST_SETTLE);
  assign locked    = locked_q;
  assign last_addr = last_addr_q;
  assign last_data = last_data_q;
endmodule

// File: rtl/spl_sector_loader.sv
module spl_sector_loader
  import spl_pkg::*;
#(
  parameter int ADDR_W        = 18,
  parameter int BYTE_W        = 8,
  parameter int DATA_W        = 8,
  parameter int BOOT_SECTS    = 32,
  parameter int TIMEOUT_TICKS = 30000,
  parameter int CYCLE_TICKS   = 4000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              prog_en,
  input  logic              lock_lo,
  input  logic              lock_hi,
  output logic              busy,
  output logic [ADDR_W-1:0] last_addr,
  output logic [DATA_W-1:0] last_data,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_data
);
  localparam int SECT_W = ADDR_W - BYTE_W;

  logic [1:0]        rst_sync_q;
  logic              srst_n;
  logic [SECT_W-1:0] sector;
  logic [BYTE_W-1:0] idx;
  logic              buf_clr, buf_we, erase_ph, prog_ph, locked, sect_locked;
  logic [DATA_W-1:0] buf_rdata;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  spl_load_ctrl #(
    .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .DATA_W(DATA_W),
    .TIMEOUT_TICKS(TIMEOUT_TICKS), .CYCLE_TICKS(CYCLE_TICKS)
  ) u_ctrl (
    .clk(clk), .rst_n(srst_n),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data), .prog_en(prog_en),
    .sect_locked(sect_locked),
    .sector(sector), .idx(idx), .buf_clr(buf_clr), .buf_we(buf_we),
    .erase_ph(erase_ph), .prog_ph(prog_ph), .busy(busy), .locked(locked),
    .last_addr(last_addr), .last_data(last_data)
  );

  spl_lock_dec #(.SECT_W(SECT_W), .BOOT_SECTS(BOOT_SECTS)) u_lock (
    .sector(sector), .lock_lo(lock_lo), .lock_hi(lock_hi), .locked(sect_locked)
  );

  spl_page_buf #(.BYTE_W(BYTE_W), .DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst_n(srst_n), .clr(buf_clr), .we(buf_we),
    .waddr(wr_addr[BYTE_W-1:0]), .wdata(wr_data),
    .raddr(idx), .rdata(buf_rdata)
  );

  assign arr_we   = (erase_ph || prog_ph) && !locked;
  assign arr_addr = {sector, idx};
  assign arr_data = erase_ph ? DATA_W'(SPL_ERASED) : buf_rdata;
endmodule

// File: rtl/spl_sector_loader_chk.sv
module spl_sector_loader_chk #(
  parameter int ADDR_W      = 18,
  parameter int BYTE_W      = 8,
  parameter int DATA_W      = 8,
  parameter int CYCLE_TICKS = 4000000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_stb,
  input logic              busy,
  input logic [ADDR_W-1:0] last_addr,
  input logic [DATA_W-1:0] last_data,
  input logic              arr_we,
  input logic [ADDR_W-1:0] arr_addr,
  input logic [DATA_W-1:0] arr_data
);
  localparam int CNT_W = $clog2(CYCLE_TICKS + 2);
  logic [CNT_W-1:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 1'b1;
    else           busy_cnt <= '0;
  end

  p_we_in_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy);

  p_one_sector_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && $past(arr_we)) |-> (arr_addr[ADDR_W-1:BYTE_W] == $past(arr_addr[ADDR_W-1:BYTE_W])));

  p_erase_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && !$past(arr_we)) |-> (arr_data == {DATA_W{1'b1}}));

  p_busy_ignores_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_stb) |=> ($stable(last_addr) && $stable(last_data)));

  p_busy_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_cnt == CNT_W'(CYCLE_TICKS)));
endmodule

bind spl_sector_loader spl_sector_loader_chk #(
  .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .DATA_W(DATA_W), .CYCLE_TICKS(CYCLE_TICKS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .busy(busy),
  .last_addr(last_addr), .last_data(last_data),
  .arr_we(arr_we), .arr_addr(arr_addr), .arr_data(arr_data)
);

// File: tb/tb_spl_sector_loader.sv
`timescale 1ns/1ps
module tb_spl_sector_loader;
  localparam int TMO = 24;
  localparam int CYC = 600;

  typedef struct packed {
    logic [9:0] sect;
    logic [7:0] first;
    logic [8:0] cnt;
    logic [7:0] stride;
    logic [7:0] seed;
    logic       lo;
    logic       hi;
    logic       commit;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{10'd5,   8'd0,   9'd256, 8'd1,   8'h10, 1'b0, 1'b0, 1'b1},
    '{10'd100, 8'd255, 9'd20,  8'd255, 8'hA0, 1'b0, 1'b0, 1'b1},
    '{10'd0,   8'd3,   9'd10,  8'd37,  8'h11, 1'b1, 1'b0, 1'b0},
    '{10'd1023,8'd8,   9'd5,   8'd2,   8'h77, 1'b0, 1'b1, 1'b0},
    '{10'd31,  8'd40,  9'd6,   8'd9,   8'h31, 1'b0, 1'b1, 1'b1},
    '{10'd992, 8'd200, 9'd7,   8'd3,   8'h52, 1'b1, 1'b0, 1'b1},
    '{10'd700, 8'd4,   9'd3,   8'd0,   8'h20, 1'b0, 1'b0, 1'b1}
  };

  logic        clk, rst_n, wr_stb, prog_en, lock_lo, lock_hi;
  logic [17:0] wr_addr;
  logic [7:0]  wr_data;
  logic        busy, arr_we;
  logic [17:0] last_addr, arr_addr;
  logic [7:0]  last_data, arr_data;

  spl_sector_loader #(.TIMEOUT_TICKS(TMO), .CYCLE_TICKS(CYC)) dut (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .prog_en(prog_en), .lock_lo(lock_lo), .lock_hi(lock_hi), .busy(busy),
    .last_addr(last_addr), .last_data(last_data),
    .arr_we(arr_we), .arr_addr(arr_addr), .arr_data(arr_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int nchk = 0, nfail = 0;
  logic [7:0] mem [logic [17:0]];
  int wcount = 0, outbad = 0, erase_bad = 0;
  logic [9:0] cur_sect = '0;
  logic [7:0] expv [256];

  // array model and ordering monitor
  always @(negedge clk) begin
    if (rst_n && arr_we) begin
      if (arr_addr[17:8] != cur_sect) outbad++;
      if (wcount < 256 && (arr_data != 8'hFF || arr_addr[7:0] != wcount[7:0])) erase_bad++;
      if (wcount >= 256 && wcount < 512 && arr_addr[7:0] != wcount[7:0]) erase_bad++;
      mem[arr_addr] = arr_data;
      wcount++;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [17:0] a, input logic [7:0] d, input logic pe);
    wr_addr = a; wr_data = d; prog_en = pe; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0; prog_en = 1'b0;
  endtask

  task automatic wait_busy(output int n);
    n = 0;
    while (!busy && n < TMO + 50) begin @(negedge clk); n++; end
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < CYC + 50) begin @(negedge clk); n++; end
  endtask

  function automatic logic [7:0] rd(input logic [17:0] a);
    return mem.exists(a) ? mem[a] : 8'h3C;
  endfunction

  task automatic preload(input logic [9:0] s);
    for (int b = 0; b < 256; b++) mem[{s, 8'(b)}] = 8'h3C;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int n, m, bad;
    logic [7:0] lb, ld, b8;
    rst_n = 1'b0; wr_stb = 1'b0; prog_en = 1'b0; lock_lo = 1'b0; lock_hi = 1'b0;
    wr_addr = '0; wr_data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(arr_we == 1'b0, "R1 arr_we", arr_we, 0);
    chk(last_addr == '0 && last_data == '0, "R1 last", {last_addr, last_data}, 0);

    // table of vectors
    for (int v = 0; v < NV; v++) begin
      vec_t t;
      t = VECS[v];
      preload(t.sect);
      for (int b = 0; b < 256; b++) expv[b] = 8'hFF;
      lock_lo = t.lo; lock_hi = t.hi;
      lb = '0; ld = '0;
      for (int i = 0; i < int'(t.cnt); i++) begin
        b8 = 8'(int'(t.first) + i * int'(t.stride));
        ld = 8'(int'(t.seed) + i * 7);
        lb = b8;
        expv[b8] = ld;
        if (i > 0) repeat (i % 3) @(negedge clk);
        do_write({t.sect, b8}, ld, i == 0);
      end
      cur_sect = t.sect; wcount = 0; outbad = 0; erase_bad = 0;
      wait_busy(n);
      chk(n == TMO, "R5 timeout", n, TMO);
      wait_idle(m);
      chk(m == CYC, "R6 busy length", m, CYC);
      chk(last_addr == {t.sect, lb} && last_data == ld, "R3 last byte",
          {last_addr, last_data}, {t.sect, lb, ld});
      bad = 0;
      for (int b = 0; b < 256; b++)
        if (rd({t.sect, 8'(b)}) != (t.commit ? expv[b] : 8'h3C)) bad++;
      chk(bad == 0, t.commit ? "R7 sector contents" : "R8 locked sector unchanged", bad, 0);
      chk(wcount == (t.commit ? 512 : 0), "R8 array write count", wcount, t.commit ? 512 : 0);
      chk(outbad == 0 && erase_bad == 0, "R7 erase order and sector", outbad + erase_bad, 0);
      lock_lo = 1'b0; lock_hi = 1'b0;
      @(negedge clk);
    end

    // R2 write without prog_en is ignored
    do_write({10'd200, 8'd0}, 8'h12, 1'b0);
    wait_busy(n);
    chk(busy == 1'b0, "R2 no load without enable", busy, 0);
    chk(last_addr == {10'd700, 8'd4}, "R2 last_addr kept", last_addr, {10'd700, 8'd4});

    // R4 foreign sector ignored, timer not restarted
    preload(10'd300); preload(10'd301);
    cur_sect = 10'd300; wcount = 0; outbad = 0; erase_bad = 0;
    do_write({10'd300, 8'd5}, 8'h55, 1'b1);
    repeat (4) @(negedge clk);
    do_write({10'd301, 8'd6}, 8'h66, 1'b1);
    chk(last_addr == {10'd300, 8'd5}, "R4 last_addr kept", last_addr, {10'd300, 8'd5});
    wait_busy(n);
    chk(n == TMO - 5, "R4 timer not restarted", n, TMO - 5);
    wait_idle(m);
    chk(rd({10'd301, 8'd6}) == 8'h3C && rd({10'd300, 8'd6}) == 8'hFF && rd({10'd300, 8'd5}) == 8'h55,
        "R4 foreign data dropped", {rd({10'd301, 8'd6}), rd({10'd300, 8'd6}), rd({10'd300, 8'd5})},
        {8'h3C, 8'hFF, 8'h55});
    chk(outbad == 0, "R7 foreign sector untouched", outbad, 0);

    // R9 writes while busy are ignored
    preload(10'd400);
    cur_sect = 10'd400; wcount = 0; outbad = 0; erase_bad = 0;
    do_write({10'd400, 8'd1}, 8'h01, 1'b1);
    wait_busy(n);
    repeat (3) @(negedge clk);
    do_write({10'd400, 8'd2}, 8'h99, 1'b1);
    chk(last_data == 8'h01, "R9 last_data kept", last_data, 8'h01);
    wait_idle(m);
    chk(rd({10'd400, 8'd2}) == 8'hFF && rd({10'd400, 8'd1}) == 8'h01, "R9 busy write dropped",
        {rd({10'd400, 8'd2}), rd({10'd400, 8'd1})}, {8'hFF, 8'h01});
    wait_busy(n);
    chk(busy == 1'b0, "R9 no new load", busy, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule